// File: doc/BRIEF.md
# Error-Tolerant Sync Word Detector

This block sits behind the clock and data recovery of a narrow-band receiver. It takes the recovered bit stream, one bit per accepted beat, into a sliding window. On every beat it compares the newest N bits of that window with the lowest N bits of a programmed sync pattern.

N is picked from four lengths. When the number of differing bit positions is no larger than a programmed error tolerance, the block raises a one-period flag. Firmware or a packet parser uses that flag as the start-of-packet alert. In multi-level reception it also fixes which received symbol boundary is the dibit boundary.

The bit input is a valid/ready stream. The block never applies back-pressure: ready is held high, and a bit is taken on every clock edge where valid is high. When valid is low the block holds all of its state. The pattern, length and tolerance inputs are plain control levels, sampled on every accepted beat. The sync flag is a plain output.

Top module: `sync_word_detector`

## Requirements
- R1: `len_sel` selects the compared length N: 2'b00 gives 12 bits, 2'b01 gives 16, 2'b10 gives 20 and 2'b11 gives 24.
- R2: `tol_sel` gives the number of accepted bit errors directly (0 to 3). A match needs the count of differing positions among the N compared bits to be less than or equal to that number.
- R3: Bits arrive most significant first. The earliest of the last N received bits is compared with `sync_pattern[N-1]`, and the latest with `sync_pattern[0]`.
- R4: `sync_found` changes only on an accepted beat. It goes high on the beat that follows the beat which shifted in the completing bit, not on the completing beat itself.
- R5: `sync_found` stays high only until the next accepted beat. It clears on that beat unless the window still matches.
- R6: While `rx_valid` is low, `rx_data` is ignored, and neither the window nor `sync_found` changes.
- R7: A synchronous reset `rst` clears `sync_found` and empties the window. No match is reported until N bits have been accepted after reset, even for an all-zero pattern.
- R8: `rx_ready` is high at all times, including during and after reset.
- R9: Pattern bits above N-1, and received bits older than the last N, have no influence on the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_valid | input | 1 | Recovered bit valid (one receive clock pulse) |
| rx_ready | output | 1 | Always high; no back-pressure |
| rx_data | input | 1 | Recovered bit |
| sync_pattern | input | 24 | Programmed sync pattern; bit 0 is the last bit sent |
| len_sel | input | 2 | Compared length select |
| tol_sel | input | 2 | Accepted bit-error count |
| sync_found | output | 1 | Sync detect flag, one receive period long |

## Verification
A bit is taken at a clock edge where `rx_valid` is high. Comparing the window it produced is due at the next such edge, because the flag is registered from the window as it stood before that edge. So the bench always sends the N word bits followed by one more bit, and samples `sync_found` at the falling edge after that extra beat. The bench also samples on the completing beat itself, and expects the flag still low there. To show that the flag is held while `rx_valid` is low, it samples across idle gaps in which `rx_data` toggles. To show that it clears at the next accepted beat, it samples right after that beat.

// File: rtl/sync_det_pkg.sv
package sync_det_pkg;

  typedef enum logic [1:0] {
    SYNC_LEN_SHORT = 2'b00,
    SYNC_LEN_MID   = 2'b01,
    SYNC_LEN_LONG  = 2'b10,
    SYNC_LEN_FULL  = 2'b11
  } sync_len_e;

  // Compared length for a length code: base plus one step per code value.
  function automatic int sync_len_bits(input sync_len_e code, input int base, input int step);
    return base + step * int'(code);
  endfunction

endpackage

// File: rtl/sync_shift_window.sv
module sync_shift_window #(
  parameter int WMAX   = 24,
  parameter int FILL_W = $clog2(WMAX + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              shift_en,
  input  logic              bit_in,
  output logic [WMAX-1:0]   window,
  output logic [FILL_W-1:0] fill
);

  localparam logic [FILL_W-1:0] FILL_MAX = FILL_W'(WMAX);

  // Newest bit enters at position 0; older bits move up.
  always_ff @(posedge clk) begin
    if (rst) begin
      window <= '0;
      fill   <= '0;
    end else if (shift_en) begin
      window <= {window[WMAX-2:0], bit_in};
      if (fill != FILL_MAX) fill <= fill + FILL_W'(1);
    end
  end

  assert_fill_bound_R7: assert property (@(posedge clk) disable iff (rst)
    fill <= FILL_MAX);

  assert_reset_empty_R7: assert property (@(posedge clk)
    rst |=> (fill == '0));

  assert_newest_bit_R3: assert property (@(posedge clk) disable iff (rst)
    shift_en |=> (window[0] == $past(bit_in)));

  assert_idle_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !shift_en |=> ($stable(window) && $stable(fill)));

endmodule

// File: rtl/sync_mismatch_count.sv
module sync_mismatch_count
  import sync_det_pkg::*;
#(
  parameter int WMAX     = 24,
  parameter int LEN_BASE = 12,
  parameter int LEN_STEP = 4,
  parameter int FILL_W   = $clog2(WMAX + 1)
) (
  input  logic [WMAX-1:0]   window,
  input  logic [WMAX-1:0]   pattern,
  input  logic [1:0]        len_sel,
  output logic [FILL_W-1:0] n_bits,
  output logic [FILL_W-1:0] err_cnt
);

  logic [WMAX-1:0] mask;
  logic [WMAX-1:0] diff;

  assign n_bits = FILL_W'(sync_len_bits(sync_len_e'(len_sel), LEN_BASE, LEN_STEP));

  // Only the lowest n_bits positions take part in the comparison.
  for (genvar g = 0; g < WMAX; g++) begin : g_mask
    assign mask[g] = (FILL_W'(g) < n_bits);
  end

  assign diff = (window ^ pattern) & mask;

  always_comb begin
    err_cnt = '0;
    for (int i = 0; i < WMAX; i++) begin
      if (diff[i]) err_cnt = err_cnt + FILL_W'(1);
    end
  end

endmodule

// File: rtl/sync_detect_flag.sv
module sync_detect_flag #(
  parameter int FILL_W = 5,
  parameter int TOL_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              beat,
  input  logic [FILL_W-1:0] fill,
  input  logic [FILL_W-1:0] n_bits,
  input  logic [FILL_W-1:0] err_cnt,
  input  logic [TOL_W-1:0]  tol,
  output logic              found
);

  logic hit;

  assign hit = (fill >= n_bits) && (err_cnt <= FILL_W'(tol));

  // Registered from the window as it stood before this beat.
  always_ff @(posedge clk) begin
    if (rst)       found <= 1'b0;
    else if (beat) found <= hit;
  end

  assert_rise_on_beat_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(found) |-> $past(beat));

  assert_flag_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !beat |=> $stable(found));

  assert_reset_clear_R7: assert property (@(posedge clk)
    rst |=> !found);

  assert_need_full_R7: assert property (@(posedge clk) disable iff (rst)
    (beat && (fill < n_bits)) |=> !found);

  assert_err_limit_R2: assert property (@(posedge clk) disable iff (rst)
    (beat && (err_cnt > FILL_W'(tol))) |=> !found);

endmodule

// File: rtl/sync_word_detector.sv
module sync_word_detector #(
  parameter int WMAX     = 24,
  parameter int LEN_BASE = 12,
  parameter int LEN_STEP = 4,
  parameter int TOL_W    = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            rx_valid,
  output logic            rx_ready,
  input  logic            rx_data,
  input  logic [WMAX-1:0] sync_pattern,
  input  logic [1:0]      len_sel,
  input  logic [TOL_W-1:0] tol_sel,
  output logic            sync_found
);

  localparam int FILL_W = $clog2(WMAX + 1);

  logic              beat;
  logic [WMAX-1:0]   window;
  logic [FILL_W-1:0] fill;
  logic [FILL_W-1:0] n_bits;
  logic [FILL_W-1:0] err_cnt;

  assign rx_ready = 1'b1;
  assign beat     = rx_valid & rx_ready;

  sync_shift_window #(.WMAX(WMAX), .FILL_W(FILL_W)) u_window (
    .clk      (clk),
    .rst      (rst),
    .shift_en (beat),
    .bit_in   (rx_data),
    .window   (window),
    .fill     (fill)
  );

  sync_mismatch_count #(
    .WMAX(WMAX), .LEN_BASE(LEN_BASE), .LEN_STEP(LEN_STEP), .FILL_W(FILL_W)
  ) u_count (
    .window  (window),
    .pattern (sync_pattern),
    .len_sel (len_sel),
    .n_bits  (n_bits),
    .err_cnt (err_cnt)
  );

  sync_detect_flag #(.FILL_W(FILL_W), .TOL_W(TOL_W)) u_flag (
    .clk     (clk),
    .rst     (rst),
    .beat    (beat),
    .fill    (fill),
    .n_bits  (n_bits),
    .err_cnt (err_cnt),
    .tol     (tol_sel),
    .found   (sync_found)
  );

  assert_ready_high_R8: assert property (@(posedge clk) rx_ready);

endmodule

// File: tb/test_sync_word_detector.sv
module test_sync_word_detector;

  localparam real CLK_NS = 5.0;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rx_valid = 1'b0;
  logic        rx_data = 1'b0;
  logic        rx_ready;
  logic [23:0] sync_pattern = '0;
  logic [1:0]  len_sel = '0;
  logic [1:0]  tol_sel = '0;
  logic        sync_found;

  int n_checks = 0;
  int n_fail   = 0;

  localparam logic [23:0] P = 24'h5A3C96;

  // {pattern, len_sel, tol_sel, flip mask on sent bits, expected flag}
  localparam logic [52:0] VEC [10] = '{
    {P,        2'd0, 2'd0, 24'h000000, 1'b1},  // R1 R3 exact 12
    {P,        2'd0, 2'd0, 24'h000001, 1'b0},  // R2 one error, tol 0
    {P,        2'd0, 2'd1, 24'h000800, 1'b1},  // R2 one error, tol 1
    {P,        2'd1, 2'd1, 24'h000300, 1'b0},  // R2 two errors, tol 1
    {P,        2'd1, 2'd2, 24'h000300, 1'b1},  // R2 two errors, tol 2
    {P,        2'd2, 2'd3, 24'h080007, 1'b0},  // R1 R2 four errors over 20
    {P,        2'd2, 2'd3, 24'h080003, 1'b1},  // R1 R2 three errors over 20
    {P,        2'd3, 2'd0, 24'h000000, 1'b1},  // R1 exact 24
    {P,        2'd3, 2'd3, 24'h800007, 1'b0},  // R1 four errors incl bit 23
    {24'hFFFC96, 2'd0, 2'd0, 24'h000000, 1'b1} // R9 upper pattern bits ignored
  };

  sync_word_detector i_sync_word_detector (
    .clk          (clk),
    .rst          (rst),
    .rx_valid     (rx_valid),
    .rx_ready     (rx_ready),
    .rx_data      (rx_data),
    .sync_pattern (sync_pattern),
    .len_sel      (len_sel),
    .tol_sel      (tol_sel),
    .sync_found   (sync_found)
  );

  always #(CLK_NS / 2.0) clk = ~clk;

  task automatic check(input logic act, input logic exp, input string tag);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; rx_valid = 1'b0;
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk); rx_valid = 1'b1; rx_data = b;
    @(negedge clk); rx_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); rx_data = ~rx_data;
    end
  endtask

  initial begin
    #(CLK_NS * 200000);
    n_fail++;
    n_checks++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    logic [23:0] stream;
    int nb;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    check(sync_found, 1'b0, "R7 flag low in reset");
    check(rx_ready, 1'b1, "R8 ready during reset");
    rst = 1'b0;
    @(negedge clk);
    check(rx_ready, 1'b1, "R8 ready after reset");

    // Table walk: N word bits, one extra bit, then sample.
    for (int v = 0; v < 10; v++) begin
      sync_pattern = VEC[v][52:29];
      len_sel      = VEC[v][28:27];
      tol_sel      = VEC[v][26:25];
      do_reset();
      stream = VEC[v][52:29] ^ VEC[v][24:1];
      nb = 12 + 4 * int'(VEC[v][28:27]);
      for (int b = nb - 1; b >= 0; b--) send_bit(stream[b]);
      send_bit(1'b0);
      check(sync_found, VEC[v][0], $sformatf("R1/R2 vector %0d", v));
    end

    // R3: same word sent least significant first must not match.
    sync_pattern = P; len_sel = 2'd0; tol_sel = 2'd3;
    do_reset();
    for (int b = 0; b < 12; b++) send_bit(P[b]);
    send_bit(1'b0);
    check(sync_found, 1'b0, "R3 reversed order rejected");

    // R4 R5 R6 R9: junk prefix, word, idle gaps with toggling data.
    tol_sel = 2'd0;
    do_reset();
    send_bit(1'b1); send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
    for (int b = 11; b >= 0; b--) send_bit(P[b]);
    check(sync_found, 1'b0, "R4 not on completing beat");
    idle(6);
    check(sync_found, 1'b0, "R6 idle does not raise flag");
    send_bit(1'b0);
    check(sync_found, 1'b1, "R4 R9 flag on next beat");
    idle(3);
    check(sync_found, 1'b1, "R6 flag held while idle");
    send_bit(1'b0);
    check(sync_found, 1'b0, "R5 flag clears next beat");

    // R7: all-zero pattern needs N bits after reset.
    sync_pattern = '0; len_sel = 2'd0; tol_sel = 2'd0;
    do_reset();
    for (int b = 0; b < 11; b++) send_bit(1'b0);
    send_bit(1'b0);
    check(sync_found, 1'b0, "R7 no match before N bits");
    send_bit(1'b0);
    check(sync_found, 1'b1, "R7 match once N bits held");
    do_reset();
    check(sync_found, 1'b0, "R7 reset clears flag");

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule